// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates six interrupt sources for a small microcontroller core: two external request lines, three timer overflow flags and a serial port whose request is formed from a receive flag and a transmit flag. Software programs an enable register and a priority register. The enable register holds one mask bit per source and a global gate. The priority register places each source in either a high or a low level. Inside a level, a fixed order decides between sources.

When a request wins, the block sends the core a one-cycle acknowledge. The acknowledge carries a 3-bit source index, the level and a 16-bit vector address. The core answers with a `taken` strobe once it has fetched the vector, and with a `reti` strobe when a handler returns. The block keeps one in-service bit per level. A high-level request can therefore interrupt a low-level handler. A request at the same level, or at a lower level, waits.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, both registers read 00h, `in_service` is 00 and `ack` is low.
- R2: A write with `cfg_sel`=0 loads the enable register and keeps bits 7 and 5..0; bit 6 reads 0. A write with `cfg_sel`=1 loads the priority register and keeps bits 5..0; bits 7..6 read 0. Source bit positions are: external 0 at bit 0, timer 0 at bit 1, external 1 at bit 2, timer 1 at bit 3, serial at bit 4, timer 2 at bit 5.
- R3: The index encoding is 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial, 5 = timer 2. When `ack` is high, `ack_vec` equals 0003h + 8 × `ack_idx`.
- R4: Within one level, the pending source with the lowest index wins.
- R5: A source whose priority bit is 1 is at the high level (`ack_lvl`=1). It beats every low-level source. Priority 04h gives the order external 1, external 0, timer 0, timer 1, serial, timer 2. Priority 0Ch gives external 1, timer 1, external 0, timer 0, serial, timer 2.
- R6: A request is eligible only if its enable bit and enable bit 7 are both set. A masked request produces no acknowledge, but it is acknowledged once it is unmasked, provided it is still asserted.
- R7: An accepted request raises `ack` for exactly one cycle, on the clock edge after the cycle in which the request is seen. After that, no further acknowledge is issued until `taken` has been high for a cycle. Requests are not accepted in a cycle where `reti` is high.
- R8: A high-level request is accepted only while the high level is not in service. A low-level request is accepted only while neither level is in service.
- R9: `reti` clears the high in-service bit if it is set; otherwise it clears the low bit.
- R10: The serial request is the OR of `req_rx` and `req_tx`.
- R11: An acknowledge sets the in-service bit of its level on the same edge that raises `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = enable register, 1 = priority register |
| cfg_wdata | input | 8 | Write data |
| en_q | output | 8 | Enable register contents |
| pri_q | output | 8 | Priority register contents |
| req_ext0 | input | 1 | External request 0 |
| req_tmr0 | input | 1 | Timer 0 overflow |
| req_ext1 | input | 1 | External request 1 |
| req_tmr1 | input | 1 | Timer 1 overflow |
| req_rx | input | 1 | Serial receive flag |
| req_tx | input | 1 | Serial transmit flag |
| req_tmr2 | input | 1 | Timer 2 overflow |
| taken | input | 1 | Core has fetched the vector |
| reti | input | 1 | Handler return strobe |
| ack | output | 1 | One-cycle acknowledge |
| ack_idx | output | 3 | Winning source index |
| ack_vec | output | 16 | Handler vector address |
| ack_lvl | output | 1 | Level of the winner (1 = high) |
| in_service | output | 2 | In-service bits, bit 1 = high level |

## Verification
A corrupted in-service bit shows up within a cycle on `in_service`. It then shows up again as a missing acknowledge (a spurious bit blocks a request) or as a wrong preemption (a lost bit lets a same-level request through). A stuck busy flag silences `ack` for good, and a lost one produces a second acknowledge before `taken`; both become visible at the next pending request. A wrong register bit appears on `en_q`/`pri_q` the cycle after the write, and as a wrong winner or a wrong level on the next acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_SRC = 6;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned N_LVL = 2;

  typedef logic [IDX_W-1:0] src_idx_t;

  typedef struct packed {
    logic     hit;
    src_idx_t idx;
  } find_t;

  // lowest set bit wins
  function automatic find_t first_of(input logic [N_SRC-1:0] v);
    find_t r;
    r.hit = 1'b0;
    r.idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.hit = 1'b1;
        r.idx = src_idx_t'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned NSRC  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] pri_q
);
  localparam int unsigned GEN_BIT = REG_W - 1;
  localparam logic [REG_W-1:0] SRC_MASK = REG_W'((1 << NSRC) - 1);
  localparam logic [REG_W-1:0] EN_MASK  = SRC_MASK | (REG_W'(1) << GEN_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pri_q <= '0;
    end else if (wr) begin
      if (sel) pri_q <= wdata & SRC_MASK;
      else     en_q  <= wdata & EN_MASK;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] pri,
  output logic             hit,
  output logic             lvl,
  output src_idx_t         idx
);
  logic [N_SRC-1:0] lvl_vec  [N_LVL];
  find_t            lvl_find [N_LVL];

  for (genvar lv = 0; lv < N_LVL; lv++) begin : g_lvl
    if (lv == 0) begin : g_low
      assign lvl_vec[lv] = pend & ~pri;
    end else begin : g_high
      assign lvl_vec[lv] = pend & pri;
    end
    assign lvl_find[lv] = first_of(lvl_vec[lv]);
  end

  always_comb begin
    if (lvl_find[1].hit) begin
      hit = 1'b1;
      lvl = 1'b1;
      idx = lvl_find[1].idx;
    end else begin
      hit = lvl_find[0].hit;
      lvl = 1'b0;
      idx = lvl_find[0].idx;
    end
  end
endmodule

// File: rtl/irq_service.sv
module irq_service
  import irq_pkg::*;
#(
  parameter int unsigned       VEC_W     = 16,
  parameter logic [VEC_W-1:0]  VEC_BASE  = 16'h0003,
  parameter int unsigned       VEC_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             lvl,
  input  src_idx_t         idx,
  input  logic             taken,
  input  logic             reti,
  output logic             ack,
  output src_idx_t         ack_idx,
  output logic [VEC_W-1:0] ack_vec,
  output logic             ack_lvl,
  output logic [N_LVL-1:0] isr
);
  logic busy;
  logic accept;
  logic lvl_free;

  // high level needs only the high bit clear; low needs both clear
  assign lvl_free = lvl ? ~isr[1] : ~|isr;
  assign accept   = hit & ~busy & ~reti & lvl_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack     <= 1'b0;
      ack_idx <= '0;
      ack_vec <= '0;
      ack_lvl <= 1'b0;
      busy    <= 1'b0;
      isr     <= '0;
    end else begin
      ack <= accept;
      if (accept) begin
        ack_idx  <= idx;
        ack_vec  <= VEC_BASE + (VEC_W'(idx) << VEC_SHIFT);
        ack_lvl  <= lvl;
        busy     <= 1'b1;
        isr[lvl] <= 1'b1;
      end else begin
        if (taken) busy <= 1'b0;
        if (reti) begin
          if (isr[1]) isr[1] <= 1'b0;
          else        isr[0] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned      REG_W     = 8,
  parameter int unsigned      VEC_W     = 16,
  parameter logic [VEC_W-1:0] VEC_BASE  = 16'h0003,
  parameter int unsigned      VEC_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] pri_q,
  input  logic             req_ext0,
  input  logic             req_tmr0,
  input  logic             req_ext1,
  input  logic             req_tmr1,
  input  logic             req_rx,
  input  logic             req_tx,
  input  logic             req_tmr2,
  input  logic             taken,
  input  logic             reti,
  output logic             ack,
  output logic [IDX_W-1:0] ack_idx,
  output logic [VEC_W-1:0] ack_vec,
  output logic             ack_lvl,
  output logic [N_LVL-1:0] in_service
);
  localparam int unsigned GEN_BIT = REG_W - 1;

  logic [N_SRC-1:0] raw_req;
  logic [N_SRC-1:0] pend;
  logic             win_hit;
  logic             win_lvl;
  src_idx_t         win_idx;

  assign raw_req = {req_tmr2, req_rx | req_tx, req_tmr1, req_ext1, req_tmr0, req_ext0};
  assign pend    = raw_req & en_q[N_SRC-1:0] & {N_SRC{en_q[GEN_BIT]}};

  irq_cfg_regs #(.REG_W(REG_W), .NSRC(N_SRC)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .en_q(en_q), .pri_q(pri_q)
  );

  irq_arbiter u_arb (
    .pend(pend), .pri(pri_q[N_SRC-1:0]),
    .hit(win_hit), .lvl(win_lvl), .idx(win_idx)
  );

  irq_service #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)) u_svc (
    .clk(clk), .rst(rst), .hit(win_hit), .lvl(win_lvl), .idx(win_idx),
    .taken(taken), .reti(reti),
    .ack(ack), .ack_idx(ack_idx), .ack_vec(ack_vec), .ack_lvl(ack_lvl),
    .isr(in_service)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned      REG_W     = 8,
  parameter int unsigned      VEC_W     = 16,
  parameter logic [VEC_W-1:0] VEC_BASE  = 16'h0003,
  parameter int unsigned      VEC_SHIFT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ack,
  input logic [2:0]       ack_idx,
  input logic [VEC_W-1:0] ack_vec,
  input logic             ack_lvl,
  input logic [1:0]       in_service,
  input logic [REG_W-1:0] en_q,
  input logic             taken,
  input logic             reti
);
  logic wait_q;

  always_ff @(posedge clk) begin
    if (rst)        wait_q <= 1'b0;
    else if (taken) wait_q <= 1'b0;
    else if (ack)   wait_q <= 1'b1;
  end

  p_ack_single_r7: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
  p_no_ack_waiting_r7: assert property (@(posedge clk) disable iff (rst) wait_q |-> !ack);
  p_vector_map_r3: assert property (@(posedge clk) disable iff (rst)
    ack |-> ack_vec == VEC_BASE + (VEC_W'(ack_idx) << VEC_SHIFT));
  p_isr_set_r11: assert property (@(posedge clk) disable iff (rst) ack |-> in_service[ack_lvl]);
  p_reti_high_r9: assert property (@(posedge clk) disable iff (rst)
    (reti && in_service[1]) |=> !in_service[1]);
  p_gate_r6: assert property (@(posedge clk) disable iff (rst) ack |-> $past(en_q[REG_W-1]));
  p_low_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && !ack_lvl) |-> $past(in_service) == 2'b00);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .REG_W(REG_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .ack_idx(ack_idx), .ack_vec(ack_vec),
  .ack_lvl(ack_lvl), .in_service(in_service), .en_q(en_q),
  .taken(taken), .reti(reti)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] en_q, pri_q;
  logic [6:0] req = '0; // {tmr2, tx, rx, tmr1, ext1, tmr0, ext0}
  logic taken = 1'b0, reti = 1'b0;
  logic ack, ack_lvl;
  logic [2:0] ack_idx;
  logic [15:0] ack_vec;
  logic [1:0] in_service;

  int tests = 0, fails = 0;
  logic [7:0] m_en = '0, m_pri = '0;
  logic [1:0] m_isr = '0;
  logic m_busy = 1'b0, e_ack = 1'b0, e_lvl = 1'b0;
  logic [2:0] e_idx = '0;

  always #2 clk = ~clk; // 250 MHz

  irq_prio_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .en_q(en_q), .pri_q(pri_q),
    .req_ext0(req[0]), .req_tmr0(req[1]), .req_ext1(req[2]), .req_tmr1(req[3]),
    .req_rx(req[4]), .req_tx(req[5]), .req_tmr2(req[6]),
    .taken(taken), .reti(reti),
    .ack(ack), .ack_idx(ack_idx), .ack_vec(ack_vec), .ack_lvl(ack_lvl),
    .in_service(in_service)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {hit, lvl, idx}: high level first, lowest index inside a level (R4, R5)
  function automatic logic [4:0] pick(input logic [5:0] pend, input logic [5:0] pri);
    logic [5:0] hi, lo;
    logic [4:0] r;
    hi = pend & pri;
    lo = pend & ~pri;
    r = '0;
    for (int i = 5; i >= 0; i--) if (lo[i]) r = {2'b10, 3'(i)};
    for (int i = 5; i >= 0; i--) if (hi[i]) r = {2'b11, 3'(i)};
    return r;
  endfunction

  task automatic tick();
    logic [5:0] pend;
    logic [4:0] p;
    logic go;
    @(posedge clk);
    // R10 serial = rx | tx; R6 enable gating
    pend = {req[6], req[5] | req[4], req[3:0]} & m_en[5:0] & {6{m_en[7]}};
    p = pick(pend, m_pri[5:0]);
    go = p[4] && !m_busy && !reti && (p[3] ? !m_isr[1] : (m_isr == 2'b00));
    e_ack = go;
    if (go) begin
      e_idx = p[2:0];
      e_lvl = p[3];
      m_isr[p[3]] = 1'b1;
      m_busy = 1'b1;
    end else begin
      if (taken) m_busy = 1'b0;
      if (reti) begin
        if (m_isr[1]) m_isr[1] = 1'b0;
        else          m_isr[0] = 1'b0;
      end
    end
    if (cfg_wr) begin
      if (cfg_sel) m_pri = cfg_wdata & 8'h3F;
      else         m_en  = cfg_wdata & 8'hBF;
    end
    @(negedge clk);
    chk(ack === e_ack, "R7 ack pulse", 32'(ack), 32'(e_ack));
    if (e_ack) begin
      chk(ack_idx === e_idx, "R4 R5 winner index", 32'(ack_idx), 32'(e_idx));
      chk(ack_lvl === e_lvl, "R5 winner level", 32'(ack_lvl), 32'(e_lvl));
      chk(ack_vec === 16'h0003 + {10'd0, e_idx, 3'd0}, "R3 vector",
          32'(ack_vec), 32'(16'h0003 + {10'd0, e_idx, 3'd0}));
    end
    chk(in_service === m_isr, "R11 R9 in-service", 32'(in_service), 32'(m_isr));
    chk(en_q === m_en, "R2 enable reg", 32'(en_q), 32'(m_en));
    chk(pri_q === m_pri, "R2 priority reg", 32'(pri_q), 32'(m_pri));
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic drop(input int idx);
    case (idx)
      4: req[5:4] = 2'b00;
      5: req[6] = 1'b0;
      default: req[idx] = 1'b0;
    endcase
  endtask

  task automatic wait_ack(input int exp_idx, input string tag);
    int n = 0;
    while (!ack && n < 10) begin tick(); n++; end
    chk(ack && ack_idx == 3'(exp_idx), tag, 32'(ack_idx), 32'(exp_idx));
  endtask

  task automatic serve(input int exp_idx, input string tag);
    wait_ack(exp_idx, tag);
    drop(exp_idx);
    taken = 1'b1; tick(); taken = 1'b0;
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_set;
    seed_set = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(en_q == 8'h00 && pri_q == 8'h00, "R1 regs after reset", {en_q, pri_q}, 0);
    chk(in_service == 2'b00 && !ack, "R1 service idle", {ack, in_service}, 0);

    // R2 reserved bits dropped
    wr_reg(1'b0, 8'hFF);
    wr_reg(1'b1, 8'hFF);
    chk(pri_q == 8'h3F, "R2 priority reserved bits", pri_q, 8'h3F);
    chk(en_q == 8'hBF, "R2 enable bit 6", en_q, 8'hBF);

    // R6 masked request waits, serviced once unmasked
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'hBE);
    req = 7'h01;
    repeat (4) tick();
    chk(!ack && in_service == 0, "R6 masked ext0 stays quiet", ack, 0);
    wr_reg(1'b0, 8'h3F); // global gate off
    repeat (3) tick();
    chk(!ack, "R6 global gate off", ack, 0);
    wr_reg(1'b0, 8'hBF);
    serve(0, "R6 unmasked ext0 serviced");

    // R10 serial from each flag
    req = 7'h20; serve(4, "R10 serial via tx");
    req = 7'h10; serve(4, "R10 serial via rx");

    // R4 fixed order at one level
    req = 7'h7F;
    serve(0, "R4 order 1"); serve(1, "R4 order 2"); serve(2, "R4 order 3");
    serve(3, "R4 order 4"); serve(4, "R4 order 5"); serve(5, "R4 order 6");

    // R5 priority 04h and 0Ch
    wr_reg(1'b1, 8'h04);
    req = 7'h7F;
    serve(2, "R5 p04 1"); serve(0, "R5 p04 2"); serve(1, "R5 p04 3");
    serve(3, "R5 p04 4"); serve(4, "R5 p04 5"); serve(5, "R5 p04 6");
    wr_reg(1'b1, 8'h0C);
    req = 7'h7F;
    serve(2, "R5 p0C 1"); serve(3, "R5 p0C 2"); serve(0, "R5 p0C 3");
    serve(1, "R5 p0C 4"); serve(4, "R5 p0C 5"); serve(5, "R5 p0C 6");

    // R8 nesting
    wr_reg(1'b1, 8'h04);
    req = 7'h02;
    wait_ack(1, "R8 low tmr0 accepted");
    chk(in_service == 2'b01, "R11 low bit set", in_service, 2'b01);
    taken = 1'b1; tick(); taken = 1'b0;
    req[0] = 1'b1;
    repeat (3) tick();
    chk(!ack, "R8 low waits on low", ack, 0);
    req[2] = 1'b1;
    wait_ack(2, "R8 high preempts low");
    taken = 1'b1; tick(); taken = 1'b0;
    chk(in_service == 2'b11, "R8 both levels active", in_service, 2'b11);
    repeat (3) tick();
    chk(!ack, "R8 same level never preempts", ack, 0);
    req[2] = 1'b0;
    reti = 1'b1; tick(); reti = 1'b0;
    chk(in_service == 2'b01, "R9 reti closes high first", in_service, 2'b01);
    repeat (2) tick();
    chk(!ack, "R8 low still blocked", ack, 0);
    reti = 1'b1; tick(); reti = 1'b0;
    wait_ack(0, "R8 ext0 after low closes");
    req = '0;
    taken = 1'b1; tick(); taken = 1'b0;
    reti = 1'b1; tick(); reti = 1'b0;

    // R7 no second ack before taken
    req = 7'h03;
    wait_ack(0, "R7 first ack");
    repeat (4) tick();
    chk(!ack, "R7 held until taken", ack, 0);
    taken = 1'b1; tick(); taken = 1'b0;
    req = '0;
    reti = 1'b1; tick(); reti = 1'b0;

    // random mix against the model
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 4) == 0) req = 7'($urandom) & 7'($urandom);
      taken = ($urandom % 3) == 0;
      reti  = ($urandom % 6) == 0;
      cfg_wr = ($urandom % 24) == 0;
      cfg_sel = $urandom % 2;
      cfg_wdata = 8'($urandom);
      if (!cfg_sel && ($urandom % 4) != 0) cfg_wdata[7] = 1'b1;
      tick();
    end
    cfg_wr = 1'b0; taken = 1'b0; reti = 1'b0; req = '0;
    tick();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule